// File: doc/BRIEF.md
# Soft-Ramping Stereo Attenuation Sequencer

This block produces the attenuation code that a stereo attenuator applies, one code per channel. Each code unit is half a decibel: code 0 passes the signal unattenuated, the deepest real attenuation sits at a configurable ceiling (227 by default, that is 113.5 dB), and the code just above that ceiling means the channel is muted. A control source writes a target code for each channel. The sequencer then walks the applied code toward that target so that level changes never jump.

The walk is paced by a one-cycle frame strobe, which comes from the edges of the sample-rate frame clock. In paced soft mode the code moves by one unit every `STEP_FRAMES` frames. In zero-cross soft mode, a channel moves by one unit only on a frame where its zero-cross indication is high. With soft mode off, the target is copied over at the next frame strobe. A mute request, or any target above the ceiling, makes the mute code the goal of the walk, so a mute fades down gently.

A busy flag shows that at least one channel has not yet reached its goal. A per-channel muted flag shows that the applied code is the mute code.

Top module: `att_ramp_seq`

## Requirements
- R1: After reset, both applied codes are 0, both muted flags are 0 and busy is 0.
- R2: A target in 0..MAX_CODE is the goal as written. A target above MAX_CODE, or an asserted mute request, makes the goal MAX_CODE+1 (228 by default). Bit 0 of `muted` (left) and bit 1 (right) are high exactly when that channel's applied code equals MAX_CODE+1.
- R3: With `soft_en`=1 and `zc_mode`=0, each applied code moves by exactly one toward its goal on every STEP_FRAMES-th frame strobe. Counting starts from the first strobe after the block leaves the idle (not busy) state, so the first step lands on strobe number STEP_FRAMES.
- R4: A ramp stops exactly on its goal. `busy` is high while any applied code differs from its goal, and low once every code has reached its goal.
- R5: A new target written during a ramp redirects the walk from the present applied code. The frame count in progress is kept and not restarted.
- R6: With `soft_en`=0, the goal is copied to the applied code on the next frame strobe.
- R7: With `soft_en`=1 and `zc_mode`=1, a channel steps by one toward its goal only on a frame strobe during which its own zero-cross input is high.
- R8: In soft mode, a mute request ramps the applied code one step at a time up to MAX_CODE+1. Releasing the request ramps the code back down toward the target.
- R9: Applied codes change only on a clock edge where `frame_tick` is high.
- R10: The two channels follow their own targets, mute requests and zero-cross inputs independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle strobe per frame clock edge |
| soft_en | input | 1 | 1 = ramp step by step, 0 = apply goal at next strobe |
| zc_mode | input | 1 | In soft mode, 1 = step on zero crossings instead of a frame count |
| tgt_l | input | CODE_W | Left target attenuation code |
| tgt_r | input | CODE_W | Right target attenuation code |
| mute_l | input | 1 | Left mute request |
| mute_r | input | 1 | Right mute request |
| zc_l | input | 1 | Left zero-cross indication |
| zc_r | input | 1 | Right zero-cross indication |
| att_l | output | CODE_W | Left applied attenuation code |
| att_r | output | CODE_W | Right applied attenuation code |
| muted | output | 2 | Per-channel muted flag, bit 0 left, bit 1 right |
| busy | output | 1 | A ramp is still in progress |

## Verification
The bench builds the block with STEP_FRAMES set to 4 and keeps the default 8-bit code with a ceiling of 227. The shorter pace makes a full fade from a low code up to the mute code, at 226 steps, fit well within the run. It also lets the bench observe a redirect that lands in the middle of a frame count, where it can tell a kept count from a restarted one. The width and ceiling stay at their defaults, so the boundary between code 227 and the codes above it is exercised exactly as the default build sees it.

// File: rtl/att_ramp_seq.sv
module att_ramp_seq #(
  parameter int CODE_W      = 8,
  parameter int MAX_CODE    = 227,
  parameter int STEP_FRAMES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              soft_en,
  input  logic              zc_mode,
  input  logic [CODE_W-1:0] tgt_l,
  input  logic [CODE_W-1:0] tgt_r,
  input  logic              mute_l,
  input  logic              mute_r,
  input  logic              zc_l,
  input  logic              zc_r,
  output logic [CODE_W-1:0] att_l,
  output logic [CODE_W-1:0] att_r,
  output logic [1:0]        muted,
  output logic              busy
);
  localparam int CNT_W = (STEP_FRAMES > 1) ? $clog2(STEP_FRAMES) : 1;
  localparam logic [CODE_W-1:0] CEIL_C = CODE_W'(MAX_CODE);
  localparam logic [CODE_W-1:0] MUTE_C = CODE_W'(MAX_CODE + 1);
  localparam logic [CNT_W-1:0]  LAST_C = CNT_W'(STEP_FRAMES - 1);

  logic [CODE_W-1:0] att_q [2];
  logic [CODE_W-1:0] goal  [2];
  logic [1:0]        zc;
  logic [CNT_W-1:0]  cnt_q;
  logic              pace;

  assign goal[0] = (mute_l || tgt_l > CEIL_C) ? MUTE_C : tgt_l;
  assign goal[1] = (mute_r || tgt_r > CEIL_C) ? MUTE_C : tgt_r;
  assign zc      = {zc_r, zc_l};
  assign pace    = frame_tick && (cnt_q == LAST_C);
  assign busy    = (att_q[0] != goal[0]) || (att_q[1] != goal[1]);
  assign att_l   = att_q[0];
  assign att_r   = att_q[1];
  assign muted   = {att_q[1] == MUTE_C, att_q[0] == MUTE_C};

  always_ff @(posedge clk) begin
    if (!rst_n || !busy)  cnt_q <= '0;
    else if (frame_tick)  cnt_q <= pace ? '0 : cnt_q + 1'b1;
  end

  for (genvar i = 0; i < 2; i++) begin : g_ch
    logic adv;
    assign adv = frame_tick && (zc_mode ? zc[i] : pace);

    always_ff @(posedge clk) begin
      if (!rst_n)                      att_q[i] <= '0;
      else if (!soft_en && frame_tick) att_q[i] <= goal[i];
      else if (soft_en && adv) begin
        if (att_q[i] < goal[i])        att_q[i] <= att_q[i] + 1'b1;
        else if (att_q[i] > goal[i])   att_q[i] <= att_q[i] - 1'b1;
      end
    end

    assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      soft_en |=> (att_q[i] == $past(att_q[i])) ||
                  (att_q[i] == $past(att_q[i]) + 1'b1) ||
                  (att_q[i] + 1'b1 == $past(att_q[i])));

    assert_ceiling_R2: assert property (@(posedge clk) disable iff (!rst_n)
      att_q[i] <= MUTE_C);

    assert_frame_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_tick |=> $stable(att_q[i]));

    assert_hold_on_goal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (att_q[i] == goal[i]) |=> $stable(att_q[i]));

    assert_no_step_without_zc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_en && zc_mode && !zc[i]) |=> $stable(att_q[i]));
  end

  assert_idle_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> cnt_q == '0);
endmodule

// File: tb/att_ramp_seq_tb_top.sv
module att_ramp_seq_tb_top;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_tick = 0, soft_en = 0, zc_mode = 0;
  logic [W-1:0] tgt_l = 0, tgt_r = 0;
  logic mute_l = 0, mute_r = 0, zc_l = 0, zc_r = 0;
  logic [W-1:0] att_l, att_r;
  logic [1:0] muted;
  logic busy;
  int vecs = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  att_ramp_seq #(.CODE_W(W), .MAX_CODE(227), .STEP_FRAMES(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .soft_en(soft_en),
    .zc_mode(zc_mode), .tgt_l(tgt_l), .tgt_r(tgt_r), .mute_l(mute_l),
    .mute_r(mute_r), .zc_l(zc_l), .zc_r(zc_r), .att_l(att_l), .att_r(att_r),
    .muted(muted), .busy(busy));

  // {tgt_l, tgt_r, mute_l, mute_r, exp_att_l, exp_att_r, exp_muted}
  localparam logic [35:0] VEC [8] = '{
    {8'd10,  8'd20,  1'b0, 1'b0, 8'd10,  8'd20,  2'b00},
    {8'd227, 8'd0,   1'b0, 1'b0, 8'd227, 8'd0,   2'b00},
    {8'd228, 8'd255, 1'b0, 1'b0, 8'd228, 8'd228, 2'b11},
    {8'd5,   8'd6,   1'b1, 1'b0, 8'd228, 8'd6,   2'b01},
    {8'd0,   8'd0,   1'b0, 1'b0, 8'd0,   8'd0,   2'b00},
    {8'd100, 8'd227, 1'b0, 1'b1, 8'd100, 8'd228, 2'b10},
    {8'd255, 8'd1,   1'b0, 1'b0, 8'd228, 8'd1,   2'b01},
    {8'd0,   8'd0,   1'b0, 1'b0, 8'd0,   8'd0,   2'b00}
  };

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frames(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) frame_tick = 1'b1;
      @(negedge clk) frame_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 att_l", att_l, 0);
    chk("R1 att_r", att_r, 0);
    chk("R1 muted", muted, 0);
    chk("R1 busy", busy, 0);

    // R6 R2 R10: soft off, table of targets
    for (int v = 0; v < 8; v++) begin
      logic [W-1:0] pl, pr;
      pl = att_l; pr = att_r;
      {tgt_l, tgt_r, mute_l, mute_r} = VEC[v][35:18];
      repeat (3) @(negedge clk);
      chk("R9 no strobe left", att_l, pl);
      chk("R9 no strobe right", att_r, pr);
      frames(1);
      chk("R6 R2 att_l", att_l, VEC[v][17:10]);
      chk("R6 R10 att_r", att_r, VEC[v][9:2]);
      chk("R2 muted", muted, VEC[v][1:0]);
      chk("R4 busy", busy, 0);
    end

    // R3 R4: paced soft ramp 0 -> 3
    soft_en = 1'b1; tgt_l = 8'd3;
    frames(3);
    chk("R3 before first step", att_l, 0);
    chk("R4 busy mid ramp", busy, 1);
    frames(1);
    chk("R3 first step", att_l, 1);
    frames(8);
    chk("R4 stop on target", att_l, 3);
    chk("R4 busy cleared", busy, 0);
    frames(4);
    chk("R4 hold on target", att_l, 3);

    // R5: redirect keeps the count
    tgt_l = 8'd6;
    frames(6);
    chk("R5 before redirect", att_l, 4);
    tgt_l = 8'd2;
    frames(1);
    chk("R5 count kept, no step yet", att_l, 4);
    frames(1);
    chk("R5 step down after redirect", att_l, 3);
    frames(4);
    chk("R5 reached new target", att_l, 2);
    chk("R4 busy after redirect", busy, 0);

    // R8: soft mute fade and release
    mute_l = 1'b1;
    frames(400);
    chk("R8 fade midway", att_l, 102);
    chk("R8 not yet muted", muted, 0);
    frames(504);
    chk("R8 reached mute", att_l, 228);
    chk("R8 muted flag", muted, 1);
    chk("R8 busy clear at mute", busy, 0);
    mute_l = 1'b0;
    frames(4);
    chk("R8 release steps down", att_l, 227);
    chk("R8 muted flag cleared", muted, 0);
    soft_en = 1'b0; tgt_l = 8'd0;
    frames(1);
    chk("R6 jump back", att_l, 0);

    // R7: zero-cross stepping on the right channel
    soft_en = 1'b1; zc_mode = 1'b1; tgt_r = 8'd2;
    frames(3);
    chk("R7 no zc no step", att_r, 0);
    chk("R7 busy waiting", busy, 1);
    zc_r = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 zc without strobe", att_r, 0);
    frames(1);
    chk("R7 step on zc", att_r, 1);
    chk("R10 left untouched", att_l, 0);
    frames(1);
    chk("R7 second step", att_r, 2);
    chk("R4 busy after zc ramp", busy, 0);

    finished = 1;
    finish_run();
  end
endmodule